// File: doc/BRIEF.md
# Procedure Signature Stack Controller

This block belongs to a control-flow watchdog that checks a running program through signatures embedded in its code. Every procedure has its own control-flow graph. When a procedure is entered, the reference signature of the caller has to be set aside, and when the procedure returns, that reference has to come back. The controller keeps these saved references on a hardware stack. It works beside a statement-level checker, which owns the current reference register and decides whether an incoming signature is a legal successor of that reference.

Each accepted signature carries a two-bit kind:

| Code | Kind |
|------|------|
| 00 | ordinary |
| 01 | procedure entry |
| 10 | procedure exit |
| 11 | treated as ordinary |

- **Procedure entry:** the current reference is pushed. The entry signature itself becomes the new reference, without any successor check.
- **Procedure exit:** the signature must first pass the statement checker's successor test. Only then is the caller's reference popped and handed back for loading.

For recovery, a checkpoint command copies the whole stack, entries and pointer, into a shadow copy. A rollback command restores the active stack from that shadow copy in one cycle, before any further signature is taken.

All outputs are registered. They appear one clock after the edge that samples the inputs.

Top module: `proc_sig_stack`

## Requirements
- R1: After reset, every output is low and the stack is empty. A checkpoint taken before any real one holds an empty stack.
- R2: An accepted entry signature (kind 01) with fewer than DEPTH entries stored does three things. It pushes `ref_cur`. It raises `ref_load` for one cycle. It presents the entry signature on `ref_next`, whatever the value of `succ_ok`.
- R3: An entry signature that arrives with DEPTH (default 16) entries stored raises `ovf_err` for one cycle. The stack is left unchanged and there is no load.
- R4: An exit signature (kind 10) with `succ_ok` high on a non-empty stack pops the most recently pushed reference. It also raises `ref_load` with that value on `ref_next`.
- R5: An exit signature with `succ_ok` low raises `seq_err` for one cycle. It neither pops nor loads.
- R6: An exit signature with `succ_ok` high on an empty stack raises `unf_err` for one cycle. It makes no load.
- R7: Signatures of kind 00 or 11 leave the stack alone and produce no output.
- R8: `ckpt_req` saves the stack pointer and all entries as they stood before any signature sampled in the same cycle.
- R9: `rollback_req` restores the pointer and entries from the last checkpoint. A signature or checkpoint request in the same cycle is discarded.
- R10: `ref_load`, `ovf_err`, `unf_err` and `seq_err` are single-cycle pulses. At most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_valid | input | 1 | Signature present this cycle |
| sig_kind | input | 2 | 00 ordinary, 01 entry, 10 exit, 11 ordinary |
| sig_data | input | SIG_W | Incoming signature |
| ref_cur | input | SIG_W | Current reference from the statement checker |
| succ_ok | input | 1 | Statement checker verdict for this signature |
| ckpt_req | input | 1 | Snapshot the stack |
| rollback_req | input | 1 | Restore the stack from the snapshot |
| ref_load | output | 1 | Load `ref_next` into the reference register |
| ref_next | output | SIG_W | New reference value |
| ovf_err | output | 1 | Push attempted on a full stack |
| unf_err | output | 1 | Pop attempted on an empty stack |
| seq_err | output | 1 | Exit signature failed the successor check |

## Verification
Two operations can land in the same cycle:

- A checkpoint with an entry or exit signature.
- A rollback with a signature or a checkpoint.

Both pairings are driven on purpose in directed steps. They also recur in a long random stream where all request lines toggle independently.

A bench model applies the stated order in each such cycle: rollback first, then the snapshot taken before the signature. Later pops then reveal which stack contents survived, so a wrong ordering shows up as a mismatched `ref_next` or a misplaced underflow.

// File: rtl/proc_sig_stack.sv
timeunit 1ns;
timeprecision 1ps;

module proc_sig_stack #(
  parameter int SIG_W = 24,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_valid,
  input  logic [1:0]       sig_kind,
  input  logic [SIG_W-1:0] sig_data,
  input  logic [SIG_W-1:0] ref_cur,
  input  logic             succ_ok,
  input  logic             ckpt_req,
  input  logic             rollback_req,
  output logic             ref_load,
  output logic [SIG_W-1:0] ref_next,
  output logic             ovf_err,
  output logic             unf_err,
  output logic             seq_err
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] K_ENTRY = 2'b01;
  localparam logic [1:0] K_EXIT  = 2'b10;

  logic [SIG_W-1:0] stk [DEPTH];
  logic [SIG_W-1:0] shd [DEPTH];
  logic [PTR_W-1:0] sp, shd_sp;

  wire take     = sig_valid && !rollback_req;
  wire is_entry = take && (sig_kind == K_ENTRY);
  wire is_exit  = take && (sig_kind == K_EXIT);
  wire full     = (sp == PTR_W'(DEPTH));
  wire empty    = (sp == '0);
  wire do_push  = is_entry && !full;
  wire do_pop   = is_exit && succ_ok && !empty;
  wire snap     = ckpt_req && !rollback_req;

  wire [IDX_W-1:0]  wr_idx = IDX_W'(sp);
  wire [IDX_W-1:0]  rd_idx = IDX_W'(sp - 1'b1);
  wire [SIG_W-1:0]  top    = stk[rd_idx];

  always_ff @(posedge clk) begin
    if (rollback_req) begin
      stk <= shd;
    end else begin
      if (snap)    shd <= stk;
      if (do_push) stk[wr_idx] <= ref_cur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp       <= '0;
      shd_sp   <= '0;
      ref_load <= 1'b0;
      ref_next <= '0;
      ovf_err  <= 1'b0;
      unf_err  <= 1'b0;
      seq_err  <= 1'b0;
    end else begin
      ref_load <= do_push || do_pop;
      if (do_push)     ref_next <= sig_data;
      else if (do_pop) ref_next <= top;
      ovf_err  <= is_entry && full;
      unf_err  <= is_exit && succ_ok && empty;
      seq_err  <= is_exit && !succ_ok;
      if (rollback_req) begin
        sp <= shd_sp;
      end else begin
        if (snap)        shd_sp <= sp;
        if (do_push)     sp <= sp + 1'b1;
        else if (do_pop) sp <= sp - 1'b1;
      end
    end
  end

  assert_depth_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= PTR_W'(DEPTH));

  assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_load, ovf_err, unf_err, seq_err}));

  assert_entry_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> ref_load && (ref_next == $past(sig_data)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_entry && full) |=> ovf_err && $stable(sp));

  assert_exit_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> ref_load && (sp == $past(sp) - 1'b1));

  assert_bad_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_exit && !succ_ok) |=> seq_err && !ref_load && $stable(sp));

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_exit && succ_ok && empty) |=> unf_err && (sp == '0));

  assert_rollback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_req |=> (sp == $past(shd_sp)) && !ref_load && $stable(shd_sp));
endmodule

// File: tb/proc_sig_stack_tb.sv
timeunit 1ns;
timeprecision 1ps;

module proc_sig_stack_tb;
  localparam int SW = 24;
  localparam int D  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sig_valid = 1'b0, succ_ok = 1'b0, ckpt_req = 1'b0, rollback_req = 1'b0;
  logic [1:0] sig_kind = '0;
  logic [SW-1:0] sig_data = '0, ref_cur = '0;
  logic ref_load, ovf_err, unf_err, seq_err;
  logic [SW-1:0] ref_next;

  proc_sig_stack #(.SIG_W(SW), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .sig_valid(sig_valid), .sig_kind(sig_kind),
    .sig_data(sig_data), .ref_cur(ref_cur), .succ_ok(succ_ok),
    .ckpt_req(ckpt_req), .rollback_req(rollback_req), .ref_load(ref_load),
    .ref_next(ref_next), .ovf_err(ovf_err), .unf_err(unf_err), .seq_err(seq_err));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [SW-1:0] m_stk [D];
  logic [SW-1:0] s_stk [D];
  int m_sp = 0, s_sp = 0;
  logic e_load, e_ovf, e_unf, e_seq;
  logic [SW-1:0] e_next;
  string tag;

  function automatic void model(input logic v, input logic [1:0] k, input logic [SW-1:0] d,
                                input logic [SW-1:0] r, input logic ok, input logic ck,
                                input logic rb);
    e_load = 0; e_ovf = 0; e_unf = 0; e_seq = 0; e_next = '0;
    tag = "R10";
    if (rb) begin
      m_stk = s_stk; m_sp = s_sp; tag = "R9";
    end else begin
      if (ck) begin s_stk = m_stk; s_sp = m_sp; tag = "R8"; end
      if (v && k == 2'b01) begin
        if (m_sp == D) begin e_ovf = 1; tag = "R3"; end
        else begin m_stk[m_sp] = r; m_sp++; e_load = 1; e_next = d; tag = "R2"; end
      end else if (v && k == 2'b10) begin
        if (!ok) begin e_seq = 1; tag = "R5"; end
        else if (m_sp == 0) begin e_unf = 1; tag = "R6"; end
        else begin m_sp--; e_load = 1; e_next = m_stk[m_sp]; tag = "R4"; end
      end else if (v) tag = "R7";
    end
  endfunction

  task automatic step(input logic v, input logic [1:0] k, input logic [SW-1:0] d,
                      input logic [SW-1:0] r, input logic ok, input logic ck, input logic rb);
    sig_valid = v; sig_kind = k; sig_data = d; ref_cur = r; succ_ok = ok;
    ckpt_req = ck; rollback_req = rb;
    model(v, k, d, r, ok, ck, rb);
    @(posedge clk);
    @(negedge clk);
    sig_valid = 0; ckpt_req = 0; rollback_req = 0;
    checks++;
    if ({ref_load, ovf_err, unf_err, seq_err} !== {e_load, e_ovf, e_unf, e_seq} ||
        (e_load && ref_next !== e_next)) begin
      errors++;
      $display("FAIL %s: load/ovf/unf/seq=%b%b%b%b next=%h expected %b%b%b%b next=%h",
               tag, ref_load, ovf_err, unf_err, seq_err, ref_next,
               e_load, e_ovf, e_unf, e_seq, e_next);
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({ref_load, ovf_err, unf_err, seq_err} !== 4'b0) begin
      errors++;
      $display("FAIL R1: outputs=%b expected 0000", {ref_load, ovf_err, unf_err, seq_err});
    end
    // R1 / R6: empty after reset, so a passing exit underflows
    step(1, 2'b10, 24'h000111, 24'h0, 1, 0, 0);
    // R1: rollback to the reset snapshot keeps the stack empty
    step(0, 2'b00, 24'h0, 24'h0, 0, 0, 1);
    step(1, 2'b10, 24'h000112, 24'h0, 1, 0, 0);
    // R2 / R3: fill to DEPTH, then one more entry overflows; succ_ok low on entries
    for (int i = 0; i < D; i++) step(1, 2'b01, 24'hA00000 + 24'(i), 24'hB00000 + 24'(i), 0, 0, 0);
    step(1, 2'b01, 24'hA0FFFF, 24'hBEEEEE, 1, 0, 0);
    step(0, 2'b00, 24'h0, 24'h0, 0, 0, 0);
    // R7: ordinary kinds do nothing
    step(1, 2'b00, 24'h123456, 24'h0, 1, 0, 0);
    step(1, 2'b11, 24'h654321, 24'h0, 1, 0, 0);
    // R5: failing exit does not pop
    step(1, 2'b10, 24'hC00000, 24'h0, 0, 0, 0);
    // R4: pops return references in reverse order
    for (int i = 0; i < 4; i++) step(1, 2'b10, 24'hC00001, 24'h0, 1, 0, 0);
    // R8: checkpoint in the same cycle as an entry captures the pre-push state
    step(1, 2'b01, 24'hD00001, 24'hE00001, 0, 1, 0);
    for (int i = 0; i < 6; i++) step(1, 2'b10, 24'hC00002, 24'h0, 1, 0, 0);
    // R9: rollback with a same-cycle exit and checkpoint discards both
    step(1, 2'b10, 24'hC00003, 24'h0, 1, 1, 1);
    for (int i = 0; i < 14; i++) step(1, 2'b10, 24'hC00004, 24'h0, 1, 0, 0);
    // R4 with checkpoint in the same cycle as an exit
    step(1, 2'b01, 24'hD00002, 24'hE00002, 1, 0, 0);
    step(1, 2'b10, 24'hC00005, 24'h0, 1, 1, 0);
    step(0, 2'b00, 24'h0, 24'h0, 0, 0, 1);
    step(1, 2'b10, 24'hC00006, 24'h0, 1, 0, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic v, ok, ck, rb;
      logic [1:0] k;
      v  = ($urandom % 8) != 0;
      k  = 2'($urandom % 4);
      ok = ($urandom % 4) != 0;
      ck = ($urandom % 16) == 0;
      rb = ($urandom % 24) == 0;
      step(v, k, 24'($urandom), 24'($urandom), ok, ck, rb);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule